// File: doc/BRIEF.md
# Serial Write-Port Receiver with CRC-8 Frame Check

This block takes write frames from a three-wire serial port and turns them into single-cycle register write strobes in the system clock domain. The serial clock, frame-select and data lines are brought into the system clock through synchronizers. Data is taken on each falling serial-clock edge while the active-low frame select is held low. When the frame select returns high, the number of bits received decides what happens to the frame.

A 16-bit frame is an unchecked write, and its word is issued at once. A 24-bit frame carries a 16-bit word followed by an 8-bit check byte. The block recomputes the check over the word and issues the write only when the two agree. A mismatch drops the write, pulls the active-low fault output low and sets a sticky error flag. A status read pulse clears the flag. Frames of any other length are thrown away.

Top module: `sfr_rx`

## Requirements
- R1: After reset, wr_en_o is 0, crc_err_o is 0 and fault_n_o is 1.
- R2: A frame of exactly 16 bits, sent most significant bit first, produces one write whose wr_data_o equals those 16 bits.
- R3: A frame of exactly 24 bits produces one write of bits 23..8 when bits 7..0 equal the CRC-8 of bits 23..8. The CRC uses generator 0x07 (x^8+x^2+x+1), starts from 0x00, processes the word MSB first, is not reflected and has no final XOR.
- R4: A 24-bit frame whose check byte does not match produces no write, sets crc_err_o to 1 and drives fault_n_o to 0.
- R5: A pulse on stat_rd_i clears crc_err_o to 0 and returns fault_n_o to 1.
- R6: A frame whose bit count is neither 16 nor 24 when the frame select rises produces no write and leaves crc_err_o unchanged. Counts above 31 saturate and are also discarded.
- R7: The error flag is sticky. Once set, a later valid write of either length leaves it set until a status read.
- R8: When a new check failure and a status read fall in the same clock cycle, the flag stays set.
- R9: Every write strobe on wr_en_o is high for exactly one clock cycle per accepted frame.
- R10: sdin_i is taken only on falling edges of sclk_i while sync_n_i is low. The bit count and shift register restart at each falling edge of sync_n_i, so serial-clock activity while the select is high has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock; data taken on its falling edge |
| sync_n_i | input | 1 | Active-low frame select |
| sdin_i | input | 1 | Serial data, MSB first |
| stat_rd_i | input | 1 | Status read pulse; clears the check error flag |
| wr_en_o | output | 1 | Single-cycle register write strobe |
| wr_data_o | output | 16 | Word written on wr_en_o |
| fault_n_o | output | 1 | Active-low fault; low while the error flag is set |
| crc_err_o | output | 1 | Sticky check error flag (status bit 3) |

## Verification
The bench sends a randomized mix of good and corrupted checked frames, plain 16-bit frames and frames of wrong length, including a 40-bit frame that drives the counter into saturation. A receiver that miscounts would write on a wrong-length frame. A wrong polynomial or bit order would reject good check bytes. A flag that is not sticky would lose the error after a later good write. Serial-clock pulses are issued while the select is high, which catches a receiver that counts outside a frame. A status read is placed exactly in the cycle of a new failure, so a clear that wins over a set shows up as a lost error.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
    localparam int DATA_W  = 16;
    localparam int CRC_W   = 8;
    localparam int FRAME_W = DATA_W + CRC_W;
    localparam int CNT_W   = $clog2(FRAME_W + 8);
endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
    parameter int       STAGES  = 2,
    parameter int       W       = 1,
    parameter logic     RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];
    logic [W-1:0] stage_d [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb stage_d[s] = d_i;
            end else begin : g_next
                always_comb stage_d[s] = stage_q[s-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= {W{RST_VAL}};
                else        stage_q[s] <= stage_d[s];
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sfr_shift.sv
module sfr_shift #(
    parameter int FRAME_W = 24,
    parameter int CNT_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart_i,
    input  logic               take_i,
    input  logic               bit_i,
    output logic [FRAME_W-1:0] shreg_o,
    output logic [CNT_W-1:0]   cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [FRAME_W-1:0] shreg;
        logic [CNT_W-1:0]   cnt;
    } shift_t;

    shift_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (restart_i) begin
            sh_d.shreg = '0;
            sh_d.cnt   = '0;
        end else if (take_i) begin
            sh_d.shreg = {sh_q.shreg[FRAME_W-2:0], bit_i};
            if (sh_q.cnt != CNT_MAX) sh_d.cnt = sh_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign shreg_o = sh_q.shreg;
    assign cnt_o   = sh_q.cnt;

    p_count_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (cnt_o == '0));
    p_count_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !restart_i && cnt_o != CNT_MAX) |=> (cnt_o == $past(cnt_o) + 1'b1));
    p_count_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_i && !restart_i) |=> $stable(cnt_o));
endmodule

// File: rtl/sfr_crc8.sv
module sfr_crc8 #(
    parameter int               DATA_W = 16,
    parameter int               CRC_W  = 8,
    parameter logic [CRC_W-1:0] POLY   = 8'h07,
    parameter logic [CRC_W-1:0] INIT   = 8'h00
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [CRC_W-1:0]  fcs_i,
    output logic [CRC_W-1:0]  crc_o,
    output logic              match_o
);
    logic [CRC_W-1:0] acc [DATA_W+1];

    assign acc[0] = INIT;

    generate
        for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            logic fb;
            assign fb = acc[i][CRC_W-1] ^ data_i[DATA_W-1-i];
            assign acc[i+1] = {acc[i][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
    endgenerate

    assign crc_o   = acc[DATA_W];
    assign match_o = (crc_o == fcs_i);
endmodule

// File: rtl/sfr_rx.sv
module sfr_rx
    import sfr_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  CRC_POLY    = 8'h07,
    parameter logic [7:0]  CRC_INIT    = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              sync_n_i,
    input  logic              sdin_i,
    input  logic              stat_rd_i,
    output logic              wr_en_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              fault_n_o,
    output logic              crc_err_o
);
    localparam logic [CNT_W-1:0] LEN_PLAIN = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] LEN_CHECK = CNT_W'(FRAME_W);

    typedef struct packed {
        logic              sclk_prev;
        logic              sync_prev;
        logic              wr_en;
        logic [DATA_W-1:0] wr_data;
        logic              err;
    } rx_t;

    rx_t rx_d, rx_q;

    logic               sclk_s, sync_s, sdin_s;
    logic               sclk_fall, sync_fall, sync_rise, take;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   cnt;
    logic [CRC_W-1:0]   crc_calc;
    logic               crc_match;
    logic               len_plain, len_check, crc_bad, wr_ok;

    sfr_sync #(.STAGES(SYNC_STAGES), .W(2), .RST_VAL(1'b1)) u_sync_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sclk_i, sync_n_i}),
        .q_o   ({sclk_s, sync_s})
    );

    sfr_sync #(.STAGES(SYNC_STAGES), .W(1), .RST_VAL(1'b0)) u_sync_dat (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (sdin_i),
        .q_o   (sdin_s)
    );

    assign sclk_fall = rx_q.sclk_prev & ~sclk_s;
    assign sync_fall = rx_q.sync_prev & ~sync_s;
    assign sync_rise = ~rx_q.sync_prev & sync_s;
    assign take      = sclk_fall & ~sync_s;

    sfr_shift #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (sync_fall),
        .take_i    (take),
        .bit_i     (sdin_s),
        .shreg_o   (shreg),
        .cnt_o     (cnt)
    );

    sfr_crc8 #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
        .data_i  (shreg[FRAME_W-1:CRC_W]),
        .fcs_i   (shreg[CRC_W-1:0]),
        .crc_o   (crc_calc),
        .match_o (crc_match)
    );

    assign len_plain = (cnt == LEN_PLAIN);
    assign len_check = (cnt == LEN_CHECK);
    assign crc_bad   = sync_rise & len_check & ~crc_match;
    assign wr_ok     = sync_rise & (len_plain | (len_check & crc_match));

    always_comb begin
        rx_d           = rx_q;
        rx_d.sclk_prev = sclk_s;
        rx_d.sync_prev = sync_s;
        rx_d.wr_en     = wr_ok;
        if (wr_ok) begin
            rx_d.wr_data = len_check ? shreg[FRAME_W-1:CRC_W] : shreg[DATA_W-1:0];
        end
        if (crc_bad)        rx_d.err = 1'b1;
        else if (stat_rd_i) rx_d.err = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q           <= '0;
            rx_q.sclk_prev <= 1'b1;
            rx_q.sync_prev <= 1'b1;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign wr_en_o   = rx_q.wr_en;
    assign wr_data_o = rx_q.wr_data;
    assign crc_err_o = rx_q.err;
    assign fault_n_o = ~rx_q.err;

    p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> !wr_en_o);
    p_bad_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_rise && len_check && !crc_match) |=> (crc_err_o && !fault_n_o));
    p_bad_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_rise && len_check && !crc_match) |=> !wr_en_o);
    p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_i && !(sync_rise && len_check && !crc_match)) |=> (!crc_err_o && fault_n_o));
    p_odd_len_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_rise && !len_plain && !len_check && !stat_rd_i) |=> (!wr_en_o && $stable(crc_err_o)));
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_err_o && !stat_rd_i) |=> crc_err_o);
    p_write_needs_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_rise |=> !wr_en_o);
endmodule

// File: tb/sfr_rx_test.sv
`timescale 1ns/1ps
module sfr_rx_test;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b1;
    logic        sync_n = 1'b1;
    logic        sdin = 1'b0;
    logic        stat_rd = 1'b0;
    logic        wr_en;
    logic [15:0] wr_data;
    logic        fault_n;
    logic        crc_err;

    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    logic [15:0] wr_last = '0;
    bit exp_flag = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sfr_rx uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_i    (sclk),
        .sync_n_i  (sync_n),
        .sdin_i    (sdin),
        .stat_rd_i (stat_rd),
        .wr_en_o   (wr_en),
        .wr_data_o (wr_data),
        .fault_n_o (fault_n),
        .crc_err_o (crc_err)
    );

    always @(negedge clk) begin
        if (wr_en) begin
            wr_cnt  <= wr_cnt + 1;
            wr_last <= wr_data;
        end
    end

    function automatic logic [7:0] ref_crc(input logic [15:0] w);
        logic [7:0] c = 8'h00;
        for (int b = 1; b >= 0; b--) begin
            c ^= w[b*8 +: 8];
            for (int k = 0; k < 8; k++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
        end
        return c;
    endfunction

    task automatic check(input bit ok, input string req, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [47:0] bits, input int n, input bit rd_at_end);
        @(negedge clk) sync_n = 1'b0;
        idle(HALF);
        for (int i = n - 1; i >= 0; i--) begin
            sdin = bits[i];
            idle(HALF);
            sclk = 1'b0;
            idle(HALF);
            sclk = 1'b1;
        end
        idle(HALF);
        sync_n = 1'b1;
        if (rd_at_end) begin
            stat_rd = 1'b1;
            repeat (3) @(posedge clk);
            @(negedge clk) stat_rd = 1'b0;
        end
        idle(12);
    endtask

    task automatic status_read();
        @(negedge clk) stat_rd = 1'b1;
        @(negedge clk) stat_rd = 1'b0;
        exp_flag = 1'b0;
        idle(2);
        check(crc_err == 1'b0 && fault_n == 1'b1, "R5",
              $sformatf("after read crc_err=%0b fault_n=%0b, expected 0/1", crc_err, fault_n));
    endtask

    task automatic verify(input string req, input int exp_w, input logic [15:0] exp_d);
        check(wr_cnt == exp_w, req, $sformatf("writes=%0d expected %0d", wr_cnt, exp_w));
        if (exp_w == 1)
            check(wr_last == exp_d, req, $sformatf("data=%h expected %h", wr_last, exp_d));
        check(crc_err == exp_flag && fault_n == !exp_flag, req,
              $sformatf("crc_err=%0b fault_n=%0b expected flag %0b", crc_err, fault_n, exp_flag));
    endtask

    task automatic plain(input logic [15:0] w, input string req);
        wr_cnt = 0;
        send_frame({32'h0, w}, 16, 1'b0);
        verify(req, 1, w);
    endtask

    task automatic checked(input logic [15:0] w, input bit corrupt, input string req);
        logic [7:0] f = ref_crc(w);
        if (corrupt) f ^= 8'(($urandom % 255) + 1);
        wr_cnt = 0;
        send_frame({24'h0, w, f}, 24, 1'b0);
        if (corrupt) exp_flag = 1'b1;
        verify(req, corrupt ? 0 : 1, w);
    endtask

    task automatic odd_len(input int n, input string req);
        wr_cnt = 0;
        send_frame({$urandom, $urandom}, n, 1'b0);
        verify(req, 0, 16'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        idle(3);
        check(wr_en == 1'b0 && crc_err == 1'b0 && fault_n == 1'b1, "R1",
              $sformatf("reset wr_en=%0b crc_err=%0b fault_n=%0b expected 0/0/1", wr_en, crc_err, fault_n));
        rst_n = 1'b1;
        idle(3);
        check(wr_en == 1'b0 && crc_err == 1'b0 && fault_n == 1'b1, "R1",
              $sformatf("idle wr_en=%0b crc_err=%0b fault_n=%0b expected 0/0/1", wr_en, crc_err, fault_n));

        // Directed corner cases
        plain(16'hA5C3, "R2");
        plain(16'h0000, "R2");
        checked(16'h1234, 1'b0, "R3");
        checked(16'hFFFF, 1'b0, "R3");
        checked(16'h8001, 1'b1, "R4");
        plain(16'h5A5A, "R7");
        checked(16'h0F0F, 1'b0, "R7");
        status_read();
        odd_len(15, "R6");
        odd_len(17, "R6");
        odd_len(40, "R6");
        checked(16'h2222, 1'b1, "R4");
        odd_len(23, "R6");
        status_read();

        // Serial clock activity while the select is high must not count (R10)
        for (int i = 0; i < 5; i++) begin
            sdin = 1'b1;
            idle(HALF); sclk = 1'b0;
            idle(HALF); sclk = 1'b1;
        end
        plain(16'h3C3C, "R10");
        checked(16'hC001, 1'b0, "R10");

        // Failure and status read in the same cycle: set wins (R8)
        begin
            logic [15:0] w = 16'h7E81;
            wr_cnt = 0;
            send_frame({24'h0, w, ref_crc(w) ^ 8'h01}, 24, 1'b1);
            exp_flag = 1'b1;
            verify("R8", 0, w);
        end
        status_read();

        // Constrained random mix
        for (int t = 0; t < 40; t++) begin
            int kind = $urandom % 5;
            logic [15:0] w = 16'($urandom);
            case (kind)
                0: plain(w, "R2");
                1: checked(w, 1'b0, "R3");
                2: checked(w, 1'b1, "R4");
                3: begin
                    int n = ($urandom % 30) + 1;
                    if (n == 16 || n == 24) n++;
                    odd_len(n, "R6");
                end
                default: status_read();
            endcase
        end

        // Every strobe single cycle (R9): a write just done leaves the strobe low afterwards
        check(wr_en == 1'b0, "R9", $sformatf("strobe=%0b expected 0 after frame", wr_en));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule